// File: doc/BRIEF.md
# Four-Channel Sampling Result Queue Bank

This block is the digital half of a four-channel sampling converter. Each channel owns a 16-deep result queue. Each cycle that a channel's trigger input is high and the channel is armed, one result is pushed into that channel's queue. The result is synthetic: a 32-bit linear congruential noise generator is stepped once for each accepted trigger, and three of its bits are added to a mid-scale base code. Software uses a 32-bit register port. It arms channels, picks the trigger source of each channel, pops results and reads every queue's pointers and full/empty flags from a packed status word. It also clears sticky overflow and underflow flags and handles one interrupt line per channel.

Writes take effect at the clock edge. Read data is combinational from the address. A read strobe on a channel's data address pops that queue at the same edge. A pop and a trigger push on the same channel in the same cycle are both carried out.

Top module: `adc_seq_bank`

## Requirements
- R1: After reset every queue status word reads 0x100 (empty, pointers 0). The enable, trigger-source, raw, mask, overflow and underflow registers read 0, every channel's select and control registers read 0, and `irq` is 0.
- R2: A trigger on channel n is accepted only when bit n of the enable register (0x000) is 1 and the 4-bit field [4n+3:4n] of the source register (0x014) equals 5. A trigger that is not accepted changes no queue, flag or noise state.
- R3: The noise state resets to 0. Each accepted trigger sets noise = noise*314159 + 1 (mod 2^32), and the pushed value is 0x200 plus noise[18:16]. When several triggers are accepted in one cycle, they are processed in ascending channel order.
- R4: A push into a non-full queue stores the value at the head, advances the head modulo 16 and clears empty. It sets full when the head reaches the tail. The status word at 0x4C+32n holds the tail in [3:0], the head in [7:4], empty in bit 8 and full in bit 12.
- R5: A push into a full queue sets overflow bit n (register 0x010), drops the value and leaves both pointers unchanged.
- R6: A read of 0x48+32n on a non-empty queue returns the entry at the tail, advances the tail modulo 16 and clears full. It sets empty when the tail reaches the head.
- R7: A read of the data address of an empty queue returns 0, sets underflow bit n (register 0x018) and leaves both pointers unchanged.
- R8: A pop and a push on the same queue in one cycle are both honoured. The pop sees the state before the push, so a full queue accepts the push without overflow and stays full, and an empty queue underflows and still takes the push.
- R9: An accepted trigger on channel n sets raw bit n (register 0x004). Writing 1s to the raw, overflow or underflow register clears those bits. A set in the same cycle wins over a clear.
- R10: `irq[n]` equals raw bit n AND mask bit n (register 0x008, 4 bits), and register 0x00C reads raw AND mask.
- R11: The channel select register (0x40+32n) keeps only the bits of 0x33333333. The channel control register (0x44+32n) keeps all 32 bits. The enable register keeps 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops on a data address) |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| trig | input | 4 | Per-channel trigger, one request per high cycle |
| irq | output | 4 | Per-channel interrupt |

## Verification
Some properties are checked on every cycle. The assertions show that a queue is never full and empty at once, that both flags imply equal pointers, that overflow and underflow events freeze the pointer they concern, that an accepted trigger always leaves its raw bit set, that a raw bit only rises on an armed channel, and that the noise state moves only when a trigger is accepted. Other behaviour needs the bench's scenarios. These are the exact result values and their ordering across channels, the pointer walk through a full wrap, data read back in push order, and the outcome of a same-cycle pop and push on an empty or a full queue. The bench also covers the priority of a set over a write-one-clear, and the register masks.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [31:0] LCG_MUL     = 32'd314159;
  localparam logic [31:0] LCG_INC     = 32'd1;
  localparam int          SAMPLE_BASE = 'h200;
  localparam logic [3:0]  SRC_EXT     = 4'd5;
  localparam logic [31:0] SEL_KEEP    = 32'h3333_3333;

  // global register offsets
  localparam int ADR_ENABLE = 'h000;
  localparam int ADR_RAW    = 'h004;
  localparam int ADR_MASK   = 'h008;
  localparam int ADR_MRAW   = 'h00C;
  localparam int ADR_OVF    = 'h010;
  localparam int ADR_SRC    = 'h014;
  localparam int ADR_UNF    = 'h018;

  // per-channel window: base + 32*n
  localparam int SEQ_BASE   = 'h040;
  localparam logic [4:0] SUB_SEL  = 5'h00;
  localparam logic [4:0] SUB_CTL  = 5'h04;
  localparam logic [4:0] SUB_DATA = 5'h08;
  localparam logic [4:0] SUB_STAT = 5'h0C;

  // status word flag positions
  localparam int ST_EMPTY_BIT = 8;
  localparam int ST_FULL_BIT  = 12;

  function automatic logic [31:0] lcg_next(input logic [31:0] s);
    return s * LCG_MUL + LCG_INC;
  endfunction

  function automatic logic [2:0] lcg_pick(input logic [31:0] s);
    return s[18:16];
  endfunction

endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [31:0]       status,
  output logic              ovf_evt,
  output logic              unf_evt
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q, head_n, tail_n;
  logic              full_q, empty_q;
  logic              do_pop, do_push, full_eff;

  // the pop is ordered before the push within one cycle
  assign do_pop   = pop & ~empty_q;
  assign unf_evt  = pop & empty_q;
  assign full_eff = full_q & ~do_pop;
  assign do_push  = push & ~full_eff;
  assign ovf_evt  = push & full_eff;

  assign tail_n = do_pop  ? tail_q + PTR_W'(1) : tail_q;
  assign head_n = do_push ? head_q + PTR_W'(1) : head_q;

  assign pop_data = empty_q ? '0 : mem[tail_q];

  always_comb begin
    status = '0;
    status[PTR_W-1:0]    = tail_q;
    status[4 +: PTR_W]   = head_q;
    status[ST_EMPTY_BIT] = empty_q;
    status[ST_FULL_BIT]  = full_q;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[head_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      head_q <= head_n;
      tail_q <= tail_n;
      if (do_push && !do_pop) begin
        empty_q <= 1'b0;
        full_q  <= (head_n == tail_n);
      end else if (do_pop && !do_push) begin
        full_q  <= 1'b0;
        empty_q <= (head_n == tail_n);
      end
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q)); // R4
  AST_FULL_PTRS_MEET: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (head_q == tail_q)); // R4
  AST_EMPTY_PTRS_MEET: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q |-> (head_q == tail_q)); // R6
  AST_OVF_HEAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (head_q == $past(head_q))); // R5
  AST_UNF_TAIL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (tail_q == $past(tail_q))); // R7
  AST_BOTH_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && pop && push) |=> full_q); // R8

endmodule

// File: rtl/adc_seq_noise.sv
module adc_seq_noise
  import adc_seq_pkg::*;
#(
  parameter int NSEQ   = 4,
  parameter int DATA_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSEQ-1:0]             accept,
  output logic [NSEQ-1:0][DATA_W-1:0] sample
);
  logic [31:0]            state_q;
  logic [NSEQ:0][31:0]    chain;
  logic [NSEQ-1:0][31:0]  stepped;

  assign chain[0] = state_q;

  // one generator step per accepted channel, lowest index first
  for (genvar k = 0; k < NSEQ; k++) begin : g_step
    assign stepped[k]  = lcg_next(chain[k]);
    assign chain[k+1]  = accept[k] ? stepped[k] : chain[k];
    assign sample[k]   = DATA_W'(SAMPLE_BASE) + DATA_W'(lcg_pick(stepped[k]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= chain[NSEQ];
  end

  AST_NOISE_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept == '0) |=> (state_q == $past(state_q))); // R2
  AST_NOISE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept != '0) |=> (state_q != $past(state_q))); // R3

endmodule

// File: rtl/adc_seq_bank.sv
module adc_seq_bank
  import adc_seq_pkg::*;
#(
  parameter int NSEQ   = 4,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NSEQ-1:0]   trig,
  output logic [NSEQ-1:0]   irq
);
  localparam int IDX_W = (NSEQ > 1) ? $clog2(NSEQ) : 1;
  localparam int HI_W  = ADDR_W - 5;
  localparam logic [HI_W-1:0]   SEQ_SPAN = HI_W'(NSEQ);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(SEQ_BASE);

  logic [NSEQ-1:0]   en_q, raw_q, msk_q, ovf_q, unf_q;
  logic [4*NSEQ-1:0] src_q;
  logic [31:0]       sel_q [NSEQ];
  logic [31:0]       ctl_q [NSEQ];

  logic [NSEQ-1:0]              accept, pop_v, ovf_evt, unf_evt;
  logic [NSEQ-1:0][DATA_W-1:0]  sample, pop_data;
  logic [NSEQ-1:0][31:0]        status;

  // address decode
  logic [ADDR_W-1:0] off;
  logic              seq_hit;
  logic [IDX_W-1:0]  seq_idx;
  logic [4:0]        sub;
  logic              glb_we;

  assign off     = reg_addr - BASE_A;
  assign seq_hit = (reg_addr >= BASE_A) && (off[ADDR_W-1:5] < SEQ_SPAN);
  assign seq_idx = off[5 +: IDX_W];
  assign sub     = reg_addr[4:0];
  assign glb_we  = reg_we && !seq_hit;

  for (genvar n = 0; n < NSEQ; n++) begin : g_seq
    logic hit_n;
    assign hit_n    = seq_hit && (seq_idx == IDX_W'(n));
    assign accept[n] = trig[n] & en_q[n] & (src_q[4*n +: 4] == SRC_EXT);
    assign pop_v[n]  = reg_re && hit_n && (sub == SUB_DATA);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[n] <= '0;
        ctl_q[n] <= '0;
      end else if (reg_we && hit_n) begin
        if (sub == SUB_SEL) sel_q[n] <= reg_wdata & SEL_KEEP;
        if (sub == SUB_CTL) ctl_q[n] <= reg_wdata;
      end
    end

    adc_seq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept[n]),
      .push_data(sample[n]),
      .pop      (pop_v[n]),
      .pop_data (pop_data[n]),
      .status   (status[n]),
      .ovf_evt  (ovf_evt[n]),
      .unf_evt  (unf_evt[n])
    );

    AST_RAW_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[n]) |-> $past(en_q[n])); // R2
  end

  adc_seq_noise #(.NSEQ(NSEQ), .DATA_W(DATA_W)) u_noise (
    .clk   (clk),
    .rst_n (rst_n),
    .accept(accept),
    .sample(sample)
  );

  // global registers; event sets win over write-one-clear
  logic [NSEQ-1:0] clr_raw, clr_ovf, clr_unf;
  assign clr_raw = (glb_we && reg_addr == ADDR_W'(ADR_RAW)) ? reg_wdata[NSEQ-1:0] : '0;
  assign clr_ovf = (glb_we && reg_addr == ADDR_W'(ADR_OVF)) ? reg_wdata[NSEQ-1:0] : '0;
  assign clr_unf = (glb_we && reg_addr == ADDR_W'(ADR_UNF)) ? reg_wdata[NSEQ-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      msk_q <= '0;
      src_q <= '0;
      raw_q <= '0;
      ovf_q <= '0;
      unf_q <= '0;
    end else begin
      if (glb_we && reg_addr == ADDR_W'(ADR_ENABLE)) en_q  <= reg_wdata[NSEQ-1:0];
      if (glb_we && reg_addr == ADDR_W'(ADR_MASK))   msk_q <= reg_wdata[NSEQ-1:0];
      if (glb_we && reg_addr == ADDR_W'(ADR_SRC))    src_q <= reg_wdata[4*NSEQ-1:0];
      raw_q <= (raw_q & ~clr_raw) | accept;
      ovf_q <= (ovf_q & ~clr_ovf) | ovf_evt;
      unf_q <= (unf_q & ~clr_unf) | unf_evt;
    end
  end

  assign irq = raw_q & msk_q;

  always_comb begin
    reg_rdata = '0;
    if (seq_hit) begin
      case (sub)
        SUB_SEL:  reg_rdata = sel_q[seq_idx];
        SUB_CTL:  reg_rdata = ctl_q[seq_idx];
        SUB_DATA: reg_rdata = {{(32-DATA_W){1'b0}}, pop_data[seq_idx]};
        SUB_STAT: reg_rdata = status[seq_idx];
        default:  reg_rdata = '0;
      endcase
    end else begin
      if (reg_addr == ADDR_W'(ADR_ENABLE)) reg_rdata[NSEQ-1:0]   = en_q;
      if (reg_addr == ADDR_W'(ADR_RAW))    reg_rdata[NSEQ-1:0]   = raw_q;
      if (reg_addr == ADDR_W'(ADR_MASK))   reg_rdata[NSEQ-1:0]   = msk_q;
      if (reg_addr == ADDR_W'(ADR_MRAW))   reg_rdata[NSEQ-1:0]   = raw_q & msk_q;
      if (reg_addr == ADDR_W'(ADR_OVF))    reg_rdata[NSEQ-1:0]   = ovf_q;
      if (reg_addr == ADDR_W'(ADR_SRC))    reg_rdata[4*NSEQ-1:0] = src_q;
      if (reg_addr == ADDR_W'(ADR_UNF))    reg_rdata[NSEQ-1:0]   = unf_q;
    end
  end

  AST_RAW_SET_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept != '0) |=> ((raw_q & $past(accept)) == $past(accept))); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt != '0) |=> ((ovf_q & $past(ovf_evt)) == $past(ovf_evt))); // R5
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt != '0) |=> ((unf_q & $past(unf_evt)) == $past(unf_evt))); // R7

endmodule

// File: tb/adc_seq_bank_tb.sv
module adc_seq_bank_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  trig = '0;
  logic [3:0]  irq;

  adc_seq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trig(trig), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model
  int          m_head [4], m_tail [4], m_cnt [4];
  logic [11:0] m_mem [4][16];
  logic [31:0] nz;
  logic [3:0]  m_raw, m_ovf, m_unf, m_en, m_msk;
  logic [15:0] m_src;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] sa(int n, int sub);
    return 12'(64 + 32 * n + sub);
  endfunction

  function automatic logic [31:0] exp_status(int n);
    logic [31:0] s;
    s = 32'(m_tail[n]) + 32'(m_head[n]) * 16;
    if (m_cnt[n] == 0)  s = s + 256;
    if (m_cnt[n] == 16) s = s + 4096;
    return s;
  endfunction

  function automatic bit armed(int n);
    return m_en[n] && (m_src[4*n +: 4] == 4'd5);
  endfunction

  task automatic m_push(int n);
    logic [11:0] v;
    nz = nz * 32'd314159 + 32'd1;
    v  = 12'd512 + 12'(nz[18:16]);
    m_raw[n] = 1'b1;
    if (m_cnt[n] == 16) m_ovf[n] = 1'b1;
    else begin
      m_mem[n][m_head[n]] = v;
      m_head[n] = (m_head[n] + 1) % 16;
      m_cnt[n]++;
    end
  endtask

  task automatic m_trig(logic [3:0] t);
    for (int n = 0; n < 4; n++) if (t[n] && armed(n)) m_push(n);
  endtask

  task automatic m_pop(int n, output logic [31:0] v);
    if (m_cnt[n] == 0) begin m_unf[n] = 1'b1; v = 0; end
    else begin
      v = 32'(m_mem[n][m_tail[n]]);
      m_tail[n] = (m_tail[n] + 1) % 16;
      m_cnt[n]--;
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_re = 1'b0;
  endtask

  task automatic pulse(logic [3:0] t);
    @(negedge clk); trig = t;
    @(posedge clk); #1 trig = '0;
    m_trig(t);
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic st_chk(string req, int n);
    rd_chk(req, sa(n, 12), exp_status(n));
  endtask

  task automatic pop_chk(string req, int n);
    logic [31:0] v, e;
    rd(sa(n, 8), v);
    m_pop(n, e);
    chk(req, v, e);
  endtask

  task automatic pop_trig_chk(string req, int n, logic [3:0] t);
    logic [31:0] v, e;
    @(negedge clk); reg_re = 1'b1; reg_addr = sa(n, 8); trig = t;
    #1 v = reg_rdata;
    @(posedge clk); #1 begin reg_re = 1'b0; trig = '0; end
    m_pop(n, e);
    m_trig(t);
    chk(req, v, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int n = 0; n < 4; n++) begin m_head[n] = 0; m_tail[n] = 0; m_cnt[n] = 0; end
    nz = '0; m_raw = '0; m_ovf = '0; m_unf = '0; m_en = '0; m_msk = '0; m_src = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int n = 0; n < 4; n++) begin
      rd_chk("R1 status", sa(n, 12), 32'h100);
      rd_chk("R1 select", sa(n, 0), 0);
      rd_chk("R1 control", sa(n, 4), 0);
    end
    rd_chk("R1 enable", 12'h000, 0);
    rd_chk("R1 raw", 12'h004, 0);
    rd_chk("R1 mask", 12'h008, 0);
    rd_chk("R1 overflow", 12'h010, 0);
    rd_chk("R1 source", 12'h014, 0);
    rd_chk("R1 underflow", 12'h018, 0);
    chk("R1 irq", {28'b0, irq}, 0);

    // R11 register masks
    for (int n = 0; n < 4; n++) begin
      wr(sa(n, 0), 32'hFFFF_FFFF);
      rd_chk("R11 select mask", sa(n, 0), 32'h3333_3333);
      wr(sa(n, 4), 32'hC0DE_0000 + 32'(n));
      rd_chk("R11 control", sa(n, 4), 32'hC0DE_0000 + 32'(n));
    end
    wr(12'h000, 32'hFF);
    rd_chk("R11 enable width", 12'h000, 32'hF);
    wr(12'h000, 0);

    // R2 disabled and wrong-source triggers are ignored
    wr(12'h014, 32'h5555); m_src = 16'h5555;
    pulse(4'hF);
    for (int n = 0; n < 4; n++) st_chk("R2 disabled", n);
    rd_chk("R2 raw disabled", 12'h004, 0);
    wr(12'h000, 32'hF); m_en = 4'hF;
    wr(12'h014, 32'h5505); m_src = 16'h5505;
    pulse(4'h2);
    st_chk("R2 wrong source", 1);
    rd_chk("R2 raw wrong source", 12'h004, 0);
    wr(12'h014, 32'h5555); m_src = 16'h5555;

    // R4/R5/R6/R7 full sweep per channel
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 16; i++) begin
        pulse(4'(1 << n));
        st_chk("R4 push status", n);
      end
      pulse(4'(1 << n));
      st_chk("R5 overflow pointers", n);
      rd_chk("R5 overflow flag", 12'h010, 32'(m_ovf));
      for (int i = 0; i < 16; i++) begin
        pop_chk("R6 R3 pop value", n);
        st_chk("R6 pop status", n);
      end
      pop_chk("R7 empty read", n);
      st_chk("R7 empty pointers", n);
      rd_chk("R7 underflow flag", 12'h018, 32'(m_unf));
      wr(12'h010, 32'hF); m_ovf = '0;
      wr(12'h018, 32'hF); m_unf = '0;
      rd_chk("R9 overflow cleared", 12'h010, 0);
      rd_chk("R9 underflow cleared", 12'h018, 0);
    end

    // R3 several channels in one cycle, ascending order
    pulse(4'hF); pulse(4'hB); pulse(4'h6);
    for (int n = 0; n < 4; n++)
      while (m_cnt[n] > 0) pop_chk("R3 ordered values", n);

    // R8 same-cycle pop and push
    pop_trig_chk("R8 empty pop with push", 2, 4'h4);
    st_chk("R8 empty pop with push status", 2);
    rd_chk("R8 underflow", 12'h018, 32'(m_unf));
    for (int i = 0; i < 15; i++) pulse(4'h4);
    st_chk("R8 filled", 2);
    pop_trig_chk("R8 full pop with push", 2, 4'h4);
    st_chk("R8 stays full", 2);
    rd_chk("R8 no overflow", 12'h010, 32'(m_ovf));
    while (m_cnt[2] > 0) pop_chk("R8 drain values", 2);

    // R9/R10 interrupts
    wr(12'h004, 32'hF); m_raw = '0;
    chk("R9 raw clear irq", {28'b0, irq}, 0);
    wr(12'h008, 32'h5); m_msk = 4'h5;
    pulse(4'h3);
    chk("R10 irq", {28'b0, irq}, {28'b0, m_raw & m_msk});
    rd_chk("R10 masked read", 12'h00C, {28'b0, m_raw & m_msk});
    rd_chk("R9 raw set", 12'h004, {28'b0, m_raw});
    @(negedge clk); reg_we = 1'b1; reg_addr = 12'h004; reg_wdata = 32'h3; trig = 4'h1;
    @(posedge clk); #1 begin reg_we = 1'b0; trig = '0; end
    m_raw = m_raw & ~4'h3; m_trig(4'h1);
    rd_chk("R9 set wins over clear", 12'h004, {28'b0, m_raw});
    chk("R10 irq after clear", {28'b0, irq}, {28'b0, m_raw & m_msk});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule